// File: doc/BRIEF.md
# Row-Hit-First DRAM Request Scheduler

This block sits between the request side of a graphics memory controller and one DRAM channel. Read and write requests, each carrying a bank, a row, a column and an identifier, are held in a bounded queue. When the scheduler is free it picks one queued request. An entry whose row is already open in its bank is preferred. If no entry hits an open row, the oldest entry is taken. It then sends the precharge, activate and column commands that request needs, each delayed until the bank timing counters allow it. A mode input switches the choice to strict arrival order. The identifier of a request is reported a fixed CAS latency after its column command.

The scheduler serves one request at a time through a small state machine. In S_IDLE it waits for a non-empty queue and latches the chosen entry (transition IDLE→PLAN). In S_PLAN it classifies that entry. A hit goes to S_COL. A different open row goes to S_PRE. A closed bank goes to S_ACT. S_PRE waits for the active-to-precharge time and then issues the precharge (PRE→ACT). S_ACT waits for the precharge period, the activate-to-activate time in the same bank and the spacing between activates to any bank, then issues the activate (ACT→COL). S_COL waits for the activate-to-column delay, issues a read or write strobe, retires the entry and returns to S_IDLE (COL→IDLE). Rows are left open after use. The queue size can be set to 32 for the baseline or 128 for the large variant.

Top module: `rowhit_sched`

## Requirements
- R1: The queue holds up to DEPTH requests. req_ready is low exactly when the queue is full, a request is taken when req_valid and req_ready are both high, and every accepted request is eventually served once.
- R2: With fifo_mode low, a queued request whose row is open in its bank is served before older requests that need a precharge or an activate.
- R3: With fifo_mode low, among several open-row hits, and among several requests when none hits, the one that arrived first is served first.
- R4: With fifo_mode high, requests are served strictly in arrival order, whatever rows are open.
- R5: A column command goes only to a bank whose open row equals the request row, and no earlier than T_RCD (12) cycles after that bank's activate.
- R6: A precharge comes no earlier than T_RAS (21) cycles after the bank's activate. An activate comes no earlier than T_RP (13) cycles after the bank's precharge, and no earlier than T_RC (34) cycles after the previous activate to the same bank.
- R7: Two activates, to any banks, are at least T_RRD (8) cycles apart.
- R8: done_valid pulses with done_id equal to the request identifier exactly T_CL (9) cycles after its column command. The column command is cmd_wr for a request with req_write=1 and cmd_rd otherwise, and cmd_col carries the request column.
- R9: After reset no command strobe and no done_valid is high, req_ready is high, and every bank is closed, so the first request to a bank is served with an activate.
- R10: A row stays open after its column command. A bank is precharged only when the request being served targets a different row in that bank, and at most one command strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_mode | input | 1 | 1 = strict arrival-order service, 0 = open-row hits first; change only while idle |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | Queue has room |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_id | input | ID_W | Request identifier |
| cmd_act | output | 1 | Activate strobe |
| cmd_pre | output | 1 | Precharge strobe |
| cmd_rd | output | 1 | Read column strobe |
| cmd_wr | output | 1 | Write column strobe |
| cmd_bank | output | BANK_W | Bank of the current command |
| cmd_row | output | ROW_W | Row for an activate |
| cmd_col | output | COL_W | Column for a read or write |
| done_valid | output | 1 | A request has completed |
| done_id | output | ID_W | Identifier of the completed request |

## Verification
The hardest case to reach is a queue that holds an open-row hit behind an older miss when the scheduler picks its next entry. A request offered to an idle block is picked alone before anything else arrives. The stimulus therefore first sends a blocking request to a closed bank, which keeps the machine busy for over a dozen cycles, and queues the miss and the hits behind it. Full-queue backpressure is reached the same way: a burst alternates rows in one bank under arrival-order service, so every request needs a slow precharge and activate pair while the queue fills.

// File: rtl/rhs_pkg.sv
`timescale 1ns/1ps
package rhs_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_PLAN,
        S_PRE,
        S_ACT,
        S_COL
    } sched_state_t;
endpackage

// File: rtl/rhs_queue.sv
`timescale 1ns/1ps
module rhs_queue #(
    parameter int DEPTH    = 32,
    parameter int EW       = 40,
    parameter int BANK_W   = 3,
    parameter int ROW_W    = 14,
    parameter int ROW_LSB  = 18,
    parameter int BANK_LSB = 32,
    localparam int IDX_W   = $clog2(DEPTH),
    localparam int CNT_W   = $clog2(DEPTH + 1),
    localparam int NBANK   = 1 << BANK_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            push,
    input  logic [EW-1:0]                   push_data,
    input  logic                            pop,
    input  logic [IDX_W-1:0]                pop_idx,
    input  logic                            fifo_mode,
    input  logic [NBANK-1:0]                open_vec,
    input  logic [NBANK-1:0][ROW_W-1:0]     open_rows,
    input  logic [IDX_W-1:0]                rd_idx,
    output logic [EW-1:0]                   rd_data,
    output logic [IDX_W-1:0]                sel_idx,
    output logic [CNT_W-1:0]                count,
    output logic                            full
);
    logic [EW-1:0]    ents [DEPTH];
    logic [EW-1:0]    nxt  [DEPTH];
    logic [DEPTH-1:0] vld, nvld, hit;
    logic [CNT_W-1:0] cnt, wr_pos;

    assign count   = cnt;
    assign full    = (cnt == CNT_W'(DEPTH));
    assign rd_data = ents[rd_idx];
    assign wr_pos  = pop ? cnt - CNT_W'(1) : cnt;

    // entry 0 is always the oldest; removal closes the gap
    always_comb begin
        nxt  = ents;
        nvld = vld;
        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (i >= int'(pop_idx)) begin
                    nxt[i]  = ents[i+1];
                    nvld[i] = vld[i+1];
                end
            end
            nxt[DEPTH-1]  = '0;
            nvld[DEPTH-1] = 1'b0;
        end
        if (push) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CNT_W'(i) == wr_pos) begin
                    nxt[i]  = push_data;
                    nvld[i] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) ents[i] <= '0;
        end else begin
            vld  <= nvld;
            ents <= nxt;
            cnt  <= cnt + CNT_W'(push) - CNT_W'(pop);
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_hit
            logic [BANK_W-1:0] bk;
            logic [ROW_W-1:0]  rw;
            assign bk     = ents[g][BANK_LSB +: BANK_W];
            assign rw     = ents[g][ROW_LSB +: ROW_W];
            assign hit[g] = vld[g] && open_vec[bk] && (open_rows[bk] == rw);
        end
    endgenerate

    // lowest index = oldest; index 0 when nothing hits or in order mode
    always_comb begin
        sel_idx = '0;
        if (!fifo_mode) begin
            for (int i = DEPTH - 1; i >= 0; i--) begin
                if (hit[i]) sel_idx = IDX_W'(i);
            end
        end
    end

    // R1
    pop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> vld[pop_idx]);
    // R1
    push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (cnt < CNT_W'(DEPTH)));
    // R1
    count_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(vld) == int'(cnt));
endmodule

// File: rtl/rhs_banks.sv
`timescale 1ns/1ps
module rhs_banks #(
    parameter int BANK_W = 3,
    parameter int ROW_W  = 14,
    parameter int AGE_W  = 7,
    localparam int NBANK = 1 << BANK_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         act,
    input  logic                         pre,
    input  logic [BANK_W-1:0]            bank,
    input  logic [ROW_W-1:0]             row,
    output logic [NBANK-1:0]             open_vec,
    output logic [NBANK-1:0][ROW_W-1:0]  open_rows,
    output logic [NBANK-1:0][AGE_W-1:0]  act_age,
    output logic [NBANK-1:0][AGE_W-1:0]  pre_age,
    output logic [AGE_W-1:0]             rrd_age
);
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    // ages count cycles since the command, saturating; reset = long ago
    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            logic this_act, this_pre;
            assign this_act = act && (bank == BANK_W'(b));
            assign this_pre = pre && (bank == BANK_W'(b));

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    open_vec[b]  <= 1'b0;
                    open_rows[b] <= '0;
                    act_age[b]   <= AGE_MAX;
                    pre_age[b]   <= AGE_MAX;
                end else begin
                    if (this_act) begin
                        open_vec[b]  <= 1'b1;
                        open_rows[b] <= row;
                    end else if (this_pre) begin
                        open_vec[b]  <= 1'b0;
                    end
                    if (this_act)                 act_age[b] <= AGE_W'(1);
                    else if (act_age[b] != AGE_MAX) act_age[b] <= act_age[b] + AGE_W'(1);
                    if (this_pre)                 pre_age[b] <= AGE_W'(1);
                    else if (pre_age[b] != AGE_MAX) pre_age[b] <= pre_age[b] + AGE_W'(1);
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)                   rrd_age <= AGE_MAX;
        else if (act)                 rrd_age <= AGE_W'(1);
        else if (rrd_age != AGE_MAX)  rrd_age <= rrd_age + AGE_W'(1);
    end
endmodule

// File: rtl/rhs_done.sv
`timescale 1ns/1ps
module rhs_done #(
    parameter int LAT  = 9,
    parameter int ID_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [ID_W-1:0] in_id,
    output logic            out_valid,
    output logic [ID_W-1:0] out_id
);
    logic            v  [LAT];
    logic [ID_W-1:0] id [LAT];

    generate
        for (genvar s = 0; s < LAT; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v[s]  <= 1'b0;
                    id[s] <= '0;
                end else if (s == 0) begin
                    v[s]  <= in_valid;
                    id[s] <= in_id;
                end else begin
                    v[s]  <= v[(s == 0) ? 0 : s - 1];
                    id[s] <= id[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign out_valid = v[LAT-1];
    assign out_id    = id[LAT-1];
endmodule

// File: rtl/rowhit_sched.sv
`timescale 1ns/1ps
module rowhit_sched
    import rhs_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int BANK_W = 3,
    parameter int ROW_W  = 14,
    parameter int COL_W  = 10,
    parameter int ID_W   = 8,
    parameter int T_CL   = 9,
    parameter int T_RP   = 13,
    parameter int T_RC   = 34,
    parameter int T_RAS  = 21,
    parameter int T_RCD  = 12,
    parameter int T_RRD  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [ID_W-1:0]   req_id,
    output logic              cmd_act,
    output logic              cmd_pre,
    output logic              cmd_rd,
    output logic              cmd_wr,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic              done_valid,
    output logic [ID_W-1:0]   done_id
);
    localparam int NBANK    = 1 << BANK_W;
    localparam int IDX_W    = $clog2(DEPTH);
    localparam int CNT_W    = $clog2(DEPTH + 1);
    localparam int COL_LSB  = ID_W;
    localparam int ROW_LSB  = COL_LSB + COL_W;
    localparam int BANK_LSB = ROW_LSB + ROW_W;
    localparam int WR_BIT   = BANK_LSB + BANK_W;
    localparam int EW       = WR_BIT + 1;
    localparam int TSUM     = T_RC + T_RAS + T_RP + T_RCD + T_RRD;
    localparam int AGE_W    = $clog2(TSUM + 1);

    sched_state_t state_q, state_d;
    logic [IDX_W-1:0] sel_q, q_sel;
    logic [CNT_W-1:0] q_count;
    logic             q_full, push, pop;
    logic [EW-1:0]    ent;

    logic [NBANK-1:0]            open_vec;
    logic [NBANK-1:0][ROW_W-1:0] open_rows;
    logic [NBANK-1:0][AGE_W-1:0] act_age, pre_age;
    logic [AGE_W-1:0]            rrd_age;

    logic              e_wr;
    logic [BANK_W-1:0] e_bank;
    logic [ROW_W-1:0]  e_row;
    logic [COL_W-1:0]  e_col;
    logic [ID_W-1:0]   e_id;
    logic bank_open, row_hit, ras_ok, act_ok, rcd_ok;

    assign req_ready = !q_full;
    assign push      = req_valid && !q_full;

    assign e_wr   = ent[WR_BIT];
    assign e_bank = ent[BANK_LSB +: BANK_W];
    assign e_row  = ent[ROW_LSB +: ROW_W];
    assign e_col  = ent[COL_LSB +: COL_W];
    assign e_id   = ent[ID_W-1:0];

    assign bank_open = open_vec[e_bank];
    assign row_hit   = bank_open && (open_rows[e_bank] == e_row);
    assign ras_ok    = act_age[e_bank] >= AGE_W'(T_RAS);
    assign act_ok    = (pre_age[e_bank] >= AGE_W'(T_RP)) &&
                       (act_age[e_bank] >= AGE_W'(T_RC)) &&
                       (rrd_age >= AGE_W'(T_RRD));
    assign rcd_ok    = act_age[e_bank] >= AGE_W'(T_RCD);

    rhs_queue #(
        .DEPTH(DEPTH), .EW(EW), .BANK_W(BANK_W), .ROW_W(ROW_W),
        .ROW_LSB(ROW_LSB), .BANK_LSB(BANK_LSB)
    ) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push(push),
        .push_data({req_write, req_bank, req_row, req_col, req_id}),
        .pop(pop), .pop_idx(sel_q),
        .fifo_mode(fifo_mode),
        .open_vec(open_vec), .open_rows(open_rows),
        .rd_idx(sel_q), .rd_data(ent),
        .sel_idx(q_sel), .count(q_count), .full(q_full)
    );

    rhs_banks #(.BANK_W(BANK_W), .ROW_W(ROW_W), .AGE_W(AGE_W)) u_banks (
        .clk(clk), .rst_n(rst_n),
        .act(cmd_act), .pre(cmd_pre), .bank(cmd_bank), .row(cmd_row),
        .open_vec(open_vec), .open_rows(open_rows),
        .act_age(act_age), .pre_age(pre_age), .rrd_age(rrd_age)
    );

    rhs_done #(.LAT(T_CL), .ID_W(ID_W)) u_done (
        .clk(clk), .rst_n(rst_n),
        .in_valid(pop), .in_id(e_id),
        .out_valid(done_valid), .out_id(done_id)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                                  sel_q <= '0;
        else if (state_q == S_IDLE && q_count != '0) sel_q <= q_sel;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (q_count != '0) state_d = S_PLAN;
            S_PLAN: begin
                if (row_hit)        state_d = S_COL;
                else if (bank_open) state_d = S_PRE;
                else                state_d = S_ACT;
            end
            S_PRE:  if (ras_ok) state_d = S_ACT;
            S_ACT:  if (act_ok) state_d = S_COL;
            S_COL:  if (rcd_ok) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_act = 1'b0;
        cmd_pre = 1'b0;
        cmd_rd  = 1'b0;
        cmd_wr  = 1'b0;
        pop     = 1'b0;
        unique case (state_q)
            S_PRE: cmd_pre = ras_ok;
            S_ACT: cmd_act = act_ok;
            S_COL: begin
                cmd_rd = rcd_ok && !e_wr;
                cmd_wr = rcd_ok && e_wr;
                pop    = rcd_ok;
            end
            default: ;
        endcase
    end

    assign cmd_bank = e_bank;
    assign cmd_row  = e_row;
    assign cmd_col  = e_col;

    // R10
    one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_act, cmd_pre, cmd_rd, cmd_wr}));
    // R10
    pre_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pre |-> (open_vec[cmd_bank] && open_rows[cmd_bank] != cmd_row));
    // R6
    pre_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pre |-> (act_age[cmd_bank] >= AGE_W'(T_RAS)));
    // R6
    act_rc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_act |-> (act_age[cmd_bank] >= AGE_W'(T_RC) && pre_age[cmd_bank] >= AGE_W'(T_RP)));
    // R7
    act_rrd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_act |-> (rrd_age >= AGE_W'(T_RRD) && !open_vec[cmd_bank]));
    // R5
    col_rcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rd || cmd_wr) |-> (open_vec[cmd_bank] && open_rows[cmd_bank] == cmd_row &&
                                act_age[cmd_bank] >= AGE_W'(T_RCD)));
    // R8
    done_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rd || cmd_wr) |=> (state_q == S_IDLE));
    // R1
    ready_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == CNT_W'(DEPTH)) |-> !req_ready);
endmodule

// File: tb/tb_rowhit_sched.sv
`timescale 1ns/1ps
module tb_rowhit_sched;
    localparam int DEPTH = 32;
    localparam int BANK_W = 3, ROW_W = 14, COL_W = 10, ID_W = 8;
    localparam int NB = 1 << BANK_W;
    localparam int T_CL = 9, T_RP = 13, T_RC = 34, T_RAS = 21, T_RCD = 12, T_RRD = 8;

    logic clk = 1'b0, rst_n = 1'b0, fifo_mode = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [BANK_W-1:0] req_bank = '0;
    logic [ROW_W-1:0]  req_row = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic [ID_W-1:0]   req_id = '0;
    logic req_ready, cmd_act, cmd_pre, cmd_rd, cmd_wr, done_valid;
    logic [BANK_W-1:0] cmd_bank;
    logic [ROW_W-1:0]  cmd_row;
    logic [COL_W-1:0]  cmd_col;
    logic [ID_W-1:0]   done_id;

    always #2.5 clk = ~clk;

    rowhit_sched #(.DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .ID_W(ID_W),
                   .T_CL(T_CL), .T_RP(T_RP), .T_RC(T_RC), .T_RAS(T_RAS), .T_RCD(T_RCD),
                   .T_RRD(T_RRD)) dut (.*);

    int checks = 0, errors = 0, cyc = 0;
    int req_bank_m [256], req_row_m [256];
    bit req_wr_m [256];
    int exp_order [$];
    int dq_id [$], dq_cyc [$];
    bit m_open [NB];
    int m_row [NB], last_act [NB], last_pre [NB];
    int last_any = -1000;
    bit seen_full = 1'b0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", rq, act, exp, cyc);
        end
    endtask

    always @(posedge clk) cyc++;

    // monitor: independent bank and ordering model
    always @(negedge clk) begin : mon
        int h, b;
        if (rst_n) begin
            b = int'(cmd_bank);
            if (!req_ready) seen_full = 1'b1;
            if (cmd_act) begin
                chk(!m_open[b], "R9 R10 activate to closed bank", int'(m_open[b]), 0);
                chk(cyc - last_act[b] >= T_RC, "R6 act-to-act same bank", cyc - last_act[b], T_RC);
                chk(cyc - last_pre[b] >= T_RP, "R6 pre-to-act", cyc - last_pre[b], T_RP);
                chk(cyc - last_any >= T_RRD, "R7 act-to-act any bank", cyc - last_any, T_RRD);
                m_open[b] = 1'b1; m_row[b] = int'(cmd_row);
                last_act[b] = cyc; last_any = cyc;
            end
            if (cmd_pre) begin
                chk(m_open[b], "R10 precharge of open bank", int'(m_open[b]), 1);
                chk(cyc - last_act[b] >= T_RAS, "R6 act-to-pre", cyc - last_act[b], T_RAS);
                if (exp_order.size() != 0) begin
                    h = exp_order[0];
                    chk(req_bank_m[h] == b && req_row_m[h] != m_row[b],
                        "R10 precharge only for a row conflict", req_row_m[h], m_row[b]);
                end else chk(1'b0, "R10 precharge with nothing pending", 0, 1);
                m_open[b] = 1'b0; last_pre[b] = cyc;
            end
            if (cmd_rd || cmd_wr) begin
                if (exp_order.size() != 0) begin
                    h = exp_order.pop_front();
                    chk(int'(cmd_col) == h, "R2 R3 R4 service order", int'(cmd_col), h);
                    chk(cmd_wr == req_wr_m[h], "R8 read/write strobe", int'(cmd_wr), int'(req_wr_m[h]));
                    chk(m_open[b] && m_row[b] == int'(cmd_row), "R5 column to open row",
                        int'(cmd_row), m_row[b]);
                    chk(cyc - last_act[b] >= T_RCD, "R5 act-to-column", cyc - last_act[b], T_RCD);
                    dq_id.push_back(h); dq_cyc.push_back(cyc + T_CL);
                end else chk(1'b0, "R1 unexpected column command", int'(cmd_col), -1);
            end
            if (done_valid) begin
                if (dq_id.size() != 0) begin
                    chk(int'(done_id) == dq_id[0], "R8 done id", int'(done_id), dq_id[0]);
                    chk(cyc == dq_cyc[0], "R8 done latency", cyc, dq_cyc[0]);
                    void'(dq_id.pop_front()); void'(dq_cyc.pop_front());
                end else chk(1'b0, "R8 unexpected done", int'(done_id), -1);
            end
        end
    end

    task automatic push_req(input bit wr, input int bank, input int row, input int id);
        req_wr_m[id] = wr; req_bank_m[id] = bank; req_row_m[id] = row;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr;
        req_bank = BANK_W'(bank); req_row = ROW_W'(row);
        req_col = COL_W'(id); req_id = ID_W'(id);
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic drain(input string rq);
        int n = 0;
        while ((exp_order.size() != 0 || dq_id.size() != 0) && n < 20000) begin
            @(negedge clk); n++;
        end
        repeat (3) @(negedge clk);
        chk(exp_order.size() == 0 && dq_id.size() == 0, rq, exp_order.size() + dq_id.size(), 0);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        for (int i = 0; i < NB; i++) begin
            m_open[i] = 1'b0; m_row[i] = -1; last_act[i] = -1000; last_pre[i] = -1000;
        end
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(req_ready == 1'b1, "R9 ready after reset", int'(req_ready), 1);
        chk({cmd_act, cmd_pre, cmd_rd, cmd_wr} == 4'b0, "R9 no strobes after reset",
            int'({cmd_act, cmd_pre, cmd_rd, cmd_wr}), 0);
        chk(done_valid == 1'b0, "R9 no done after reset", int'(done_valid), 0);

        // single read to a closed bank: activate, column, done (R5 R8 R9)
        exp_order.push_back(1);
        push_req(1'b0, 0, 5, 1);
        drain("R5 R8 single read completes");

        // row hit preferred over older miss, oldest hit first (R2 R3)
        exp_order.push_back(10); exp_order.push_back(12);
        exp_order.push_back(13); exp_order.push_back(11);
        push_req(1'b0, 1, 3, 10);
        push_req(1'b0, 0, 7, 11);
        push_req(1'b0, 0, 5, 12);
        push_req(1'b1, 0, 5, 13);
        drain("R2 R3 hit-first group completes");

        // oldest miss first among misses, hit still ahead of them (R3 R7)
        exp_order.push_back(20); exp_order.push_back(23);
        exp_order.push_back(21); exp_order.push_back(22);
        push_req(1'b1, 2, 1, 20);
        push_req(1'b0, 3, 4, 21);
        push_req(1'b1, 4, 4, 22);
        push_req(1'b0, 2, 1, 23);
        drain("R3 R7 miss ordering completes");

        // in-order mode ignores the open row (R4 R6 R10)
        fifo_mode = 1'b1;
        exp_order.push_back(30); exp_order.push_back(31); exp_order.push_back(32);
        push_req(1'b0, 5, 2, 30);
        push_req(1'b0, 0, 9, 31);
        push_req(1'b1, 0, 7, 32);
        drain("R4 R6 in-order group completes");

        // burst beyond capacity: backpressure, no loss, order kept (R1 R4)
        for (int k = 0; k < DEPTH + 4; k++) exp_order.push_back(100 + k);
        for (int k = 0; k < DEPTH + 4; k++) push_req(k[0], 6, 1 + (k % 2), 100 + k);
        chk(seen_full, "R1 ready low when queue full", int'(seen_full), 1);
        drain("R1 R4 burst fully served");
        chk(req_ready == 1'b1, "R1 ready back after drain", int'(req_ready), 1);

        // back to hit-first on the same bank that burst used (R2 R10)
        fifo_mode = 1'b0;
        exp_order.push_back(200); exp_order.push_back(202); exp_order.push_back(201);
        push_req(1'b0, 7, 8, 200);
        push_req(1'b0, 6, 1, 201);
        push_req(1'b1, 6, 2, 202);
        drain("R2 R10 open row kept and reused");

        report();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        report();
        $finish;
    end
endmodule